// File: doc/BRIEF.md
# Converter Status and Interrupt Flag Register

This block collects the hardware events of an analog-to-digital converter controller into a set of sticky status flags. Software reads the flags and clears them over a small register bus. The sequencer supplies single-cycle pulses for six events: converter ready, sampling finished, one channel converted, channel set finished, calibration finished and internal regulator ready. Each conversion pulse comes with its result. The block latches that result into a data register and compares it with a programmable low and high threshold. From the same pulses it also derives an overrun flag and a window-violation flag.

A software-writable mask selects which flags may raise the single interrupt output. The output is registered, so it follows the flags by one clock. Reading the data register consumes the pending result, which clears the conversion flag without a separate write. Flags that are set are never lost to a clear that arrives in the same cycle.

Top module: `adc_isr_top`

## Requirements
- R1: After reset the status register, the enable mask, the data register, the low threshold and `irq` all read 0. The high threshold reads all ones (DATA_W bits).
- R2: Each event pulse sets its own flag in the status word (bus address 0): ready at bit 0, sampling end at bit 1, conversion end at bit 2, channel-set end at bit 3, calibration done at bit 11 and regulator ready at bit 12. The flag is visible on the next cycle.
- R3: Writing 1 to a status bit clears that flag. Writing 0 leaves it unchanged. Bits 5, 6, 8 to 10 and 13 upward always read 0.
- R4: When a set event and a software clear reach the same flag in one cycle, the flag ends up set.
- R5: A conversion-end pulse stores `conv_data` into the data register (address 4) and sets bit 2. A bus read of address 4 returns the stored result and clears bit 2.
- R6: A conversion-end pulse that arrives while bit 2 is set and not being cleared in that cycle sets the overrun flag at bit 4. The data register takes the newest result and bit 2 stays set.
- R7: A conversion-end pulse in the same cycle as a data-register read, or as a write-1 to bit 2, leaves bit 2 set and does not set bit 4. The read returns the older result.
- R8: A conversion result strictly below the low threshold (address 2) or strictly above the high threshold (address 3) sets the window flag at bit 7. Results equal to either threshold do not set it.
- R9: `irq` is 1 exactly one cycle after any flag is set whose enable bit (address 1, same bit positions as the status word) is 1. It returns to 0 one cycle after no enabled flag remains.
- R10: The enable mask reads back only the eight flag positions (mask 0x189F). Each threshold reads back its low DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ready | input | 1 | Converter ready pulse |
| ev_smp_end | input | 1 | Sampling phase finished pulse |
| ev_conv_end | input | 1 | One channel converted pulse |
| conv_data | input | DATA_W | Result that accompanies ev_conv_end |
| ev_seq_end | input | 1 | Last channel of the selected set converted |
| ev_cal_done | input | 1 | Calibration finished pulse |
| ev_ldo_ready | input | 1 | Internal regulator ready pulse |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address: 0 status, 1 enable, 2 low, 3 high, 4 data |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational from the addressed register |
| irq | output | 1 | Registered interrupt request |

## Verification
The case that matters is a new conversion completing in the very cycle that software consumes the previous one. The consuming access can be either a data-register read or a write-1 to the conversion flag. The bench provokes this by raising `ev_conv_end` with a fresh result during the bus read strobe, and again during a status write. It judges the outcome at the ports. The read must return the older result, the conversion flag must remain set, the overrun flag must stay clear, and a following read must return the newer result. A second collision pairs the ready pulse with a write-1 to its own bit, and the flag must survive.

// File: rtl/adc_isr_pkg.sv
`timescale 1ns/1ps
package adc_isr_pkg;
    localparam int NFLAG = 8;

    // compact flag index -> bit position in the status word
    localparam int FLAG_POS [NFLAG] = '{0, 1, 2, 3, 4, 7, 11, 12};

    localparam int IX_RDY = 0;
    localparam int IX_SMP = 1;
    localparam int IX_EOC = 2;
    localparam int IX_EOS = 3;
    localparam int IX_OVR = 4;
    localparam int IX_WIN = 5;
    localparam int IX_CAL = 6;
    localparam int IX_LDO = 7;

    localparam logic [2:0] A_STAT = 3'd0;
    localparam logic [2:0] A_EN   = 3'd1;
    localparam logic [2:0] A_LOW  = 3'd2;
    localparam logic [2:0] A_HIGH = 3'd3;
    localparam logic [2:0] A_DATA = 3'd4;
endpackage

// File: rtl/isr_flag_cell.sv
`timescale 1ns/1ps
// One sticky flag: set has priority over clear.
module isr_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end
endmodule

// File: rtl/isr_win_check.sv
`timescale 1ns/1ps
// Flags a result that lies outside the inclusive window [low, high].
module isr_win_check #(
    parameter int W = 12
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] low,
    input  logic [W-1:0] high,
    output logic         outside
);
    always_comb outside = (value < low) || (value > high);
endmodule

// File: rtl/isr_irq_gen.sv
`timescale 1ns/1ps
// Masked OR of the flags, registered once.
module isr_irq_gen #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] mask,
    output logic         irq
);
    logic any_hit;
    always_comb any_hit = |(flags & mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= any_hit;
    end
endmodule

// File: rtl/adc_isr_top.sv
`timescale 1ns/1ps
module adc_isr_top
    import adc_isr_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ready,
    input  logic              ev_smp_end,
    input  logic              ev_conv_end,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              ev_seq_end,
    input  logic              ev_cal_done,
    input  logic              ev_ldo_ready,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam logic [DATA_W-1:0] HIGH_RST = {DATA_W{1'b1}};

    logic [NFLAG-1:0]  flag_q;
    logic [NFLAG-1:0]  en_q;
    logic [NFLAG-1:0]  set_vec;
    logic [NFLAG-1:0]  clr_vec;
    logic [NFLAG-1:0]  wbits;
    logic [DATA_W-1:0] low_q, high_q, data_q;
    logic [BUS_W-1:0]  stat_word, en_word;
    logic              wr_stat, wr_en, wr_low, wr_high, rd_data;
    logic              clr_any, eoc_drop, ovr_ev, win_ev, outside;
    logic              unused_wdata;

    // ---------------- bus decode ----------------
    always_comb begin
        wr_stat = bus_sel &&  bus_wr && (bus_addr == A_STAT);
        wr_en   = bus_sel &&  bus_wr && (bus_addr == A_EN);
        wr_low  = bus_sel &&  bus_wr && (bus_addr == A_LOW);
        wr_high = bus_sel &&  bus_wr && (bus_addr == A_HIGH);
        rd_data = bus_sel && !bus_wr && (bus_addr == A_DATA);
        clr_any = wr_stat || rd_data;
    end

    assign unused_wdata = ^bus_wdata;

    // gather write data from the flag positions, spread flags back out
    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_pos
            assign wbits[i] = bus_wdata[FLAG_POS[i]];
        end
    endgenerate

    always_comb begin
        stat_word = '0;
        en_word   = '0;
        for (int i = 0; i < NFLAG; i++) begin
            stat_word[FLAG_POS[i]] = flag_q[i];
            en_word[FLAG_POS[i]]   = en_q[i];
        end
    end

    // ---------------- derived events ----------------
    isr_win_check #(.W(DATA_W)) u_win (
        .value   (conv_data),
        .low     (low_q),
        .high    (high_q),
        .outside (outside)
    );

    always_comb begin
        clr_vec = wr_stat ? wbits : '0;
        clr_vec[IX_EOC] = clr_vec[IX_EOC] || rd_data;
        eoc_drop = clr_vec[IX_EOC];
        // overrun only if the pending result is not being consumed now
        ovr_ev = ev_conv_end && flag_q[IX_EOC] && !eoc_drop;
        win_ev = ev_conv_end && outside;

        set_vec          = '0;
        set_vec[IX_RDY]  = ev_ready;
        set_vec[IX_SMP]  = ev_smp_end;
        set_vec[IX_EOC]  = ev_conv_end;
        set_vec[IX_EOS]  = ev_seq_end;
        set_vec[IX_OVR]  = ovr_ev;
        set_vec[IX_WIN]  = win_ev;
        set_vec[IX_CAL]  = ev_cal_done;
        set_vec[IX_LDO]  = ev_ldo_ready;
    end

    // ---------------- flags ----------------
    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            isr_flag_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_vec[i]),
                .clr_i (clr_vec[i]),
                .q     (flag_q[i])
            );
        end
    endgenerate

    // ---------------- configuration and data ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            low_q  <= '0;
            high_q <= HIGH_RST;
            data_q <= '0;
        end else begin
            if (wr_en)       en_q   <= wbits;
            if (wr_low)      low_q  <= bus_wdata[DATA_W-1:0];
            if (wr_high)     high_q <= bus_wdata[DATA_W-1:0];
            if (ev_conv_end) data_q <= conv_data;
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        case (bus_addr)
            A_STAT:  bus_rdata = stat_word;
            A_EN:    bus_rdata = en_word;
            A_LOW:   bus_rdata = BUS_W'(low_q);
            A_HIGH:  bus_rdata = BUS_W'(high_q);
            A_DATA:  bus_rdata = BUS_W'(data_q);
            default: bus_rdata = '0;
        endcase
    end

    // ---------------- interrupt ----------------
    isr_irq_gen #(.N(NFLAG)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (flag_q),
        .mask  (en_q),
        .irq   (irq)
    );
endmodule

// File: rtl/adc_isr_chk.sv
`timescale 1ns/1ps
module adc_isr_chk #(
    parameter int NFLAG  = 8,
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_ready,
    input logic              ev_conv_end,
    input logic [DATA_W-1:0] conv_data,
    input logic              clr_any,
    input logic              eoc_drop,
    input logic [NFLAG-1:0]  flag_q,
    input logic [NFLAG-1:0]  en_q,
    input logic [DATA_W-1:0] data_q,
    input logic              irq
);
    p_ready_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ready |=> flag_q[0]);

    p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ready && clr_any) |=> flag_q[0]);

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_any |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_conv_end |=> (flag_q[2] && data_q == $past(conv_data)));

    p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_conv_end && flag_q[2] && !eoc_drop) |=> flag_q[4]);

    p_no_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_conv_end && eoc_drop && !flag_q[4]) |=> !flag_q[4]);

    p_irq_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(flag_q & en_q)));
endmodule

bind adc_isr_top adc_isr_chk #(.NFLAG(adc_isr_pkg::NFLAG), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_ready    (ev_ready),
    .ev_conv_end (ev_conv_end),
    .conv_data   (conv_data),
    .clr_any     (clr_any),
    .eoc_drop    (eoc_drop),
    .flag_q      (flag_q),
    .en_q        (en_q),
    .data_q      (data_q),
    .irq         (irq)
);

// File: tb/sim_adc_isr_top.sv
`timescale 1ns/1ps
module sim_adc_isr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_ready = 0, ev_smp_end = 0, ev_conv_end = 0, ev_seq_end = 0;
    logic        ev_cal_done = 0, ev_ldo_ready = 0;
    logic [11:0] conv_data = '0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    adc_isr_top u0 (
        .clk(clk), .rst_n(rst_n), .ev_ready(ev_ready), .ev_smp_end(ev_smp_end),
        .ev_conv_end(ev_conv_end), .conv_data(conv_data), .ev_seq_end(ev_seq_end),
        .ev_cal_done(ev_cal_done), .ev_ldo_ready(ev_ldo_ready), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        bus_sel = 0; bus_wr = 0;
        ev_ready = 0; ev_smp_end = 0; ev_conv_end = 0; ev_seq_end = 0;
        ev_cal_done = 0; ev_ldo_ready = 0;
    endtask

    task automatic do_wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); idle();
    endtask

    task automatic do_rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); idle();
    endtask

    // k: 0 ready, 1 sampling end, 2 conversion end, 3 set end, 6 calibration, 7 regulator
    task automatic set_ev(int k, logic [11:0] d);
        case (k)
            0: ev_ready = 1;
            1: ev_smp_end = 1;
            2: begin ev_conv_end = 1; conv_data = d; end
            3: ev_seq_end = 1;
            6: ev_cal_done = 1;
            default: ev_ldo_ready = 1;
        endcase
    endtask

    task automatic pulse(int k, logic [11:0] d);
        @(negedge clk); set_ev(k, d);
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1", "irq", {31'd0, irq}, 0);
        do_rd(0, r); check("R1", "status", r, 0);
        do_rd(1, r); check("R1", "enable", r, 0);
        do_rd(2, r); check("R1", "low", r, 0);
        do_rd(3, r); check("R1", "high", r, 32'hFFF);
        do_rd(4, r); check("R1", "data", r, 0);
    endtask

    task automatic t_flags();
        logic [31:0] r;
        int pos [8] = '{0, 1, 2, 3, 4, 7, 11, 12};
        foreach (pos[k]) begin
            if (k == 4 || k == 5) continue;
            pulse(k, 12'h400);
            do_rd(0, r); check("R2", "single flag", r, 32'h1 << pos[k]);
            do_wr(0, 32'h0);
            do_rd(0, r); check("R3", "write 0 keeps", r, 32'h1 << pos[k]);
            do_wr(0, 32'h1 << pos[k]);
            do_rd(0, r); check("R3", "write 1 clears", r, 0);
        end
        pulse(0, 0); pulse(3, 0); pulse(6, 0); pulse(7, 0);
        do_wr(0, 32'h0000_0008);
        do_rd(0, r); check("R3", "partial clear", r, 32'h1801);
        do_wr(0, 32'hFFFF_FFFF);
        do_rd(0, r); check("R3", "clear all, unused zero", r, 0);
    endtask

    task automatic t_set_wins();
        logic [31:0] r;
        pulse(0, 0);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 32'h1; ev_ready = 1;
        @(negedge clk); idle();
        do_rd(0, r); check("R4", "set beats clear", r, 32'h1);
        do_wr(0, 32'hFFFF_FFFF);
    endtask

    task automatic t_data_read();
        logic [31:0] r;
        pulse(2, 12'h123);
        do_rd(0, r); check("R5", "eoc set", r, 32'h4);
        do_rd(4, r); check("R5", "data value", r, 32'h123);
        do_rd(0, r); check("R5", "read clears eoc", r, 0);
    endtask

    task automatic t_overrun();
        logic [31:0] r;
        pulse(2, 12'h111);
        pulse(2, 12'h222);
        do_rd(0, r); check("R6", "eoc and ovr", r, 32'h14);
        do_rd(4, r); check("R6", "newest data", r, 32'h222);
        do_wr(0, 32'hFFFF_FFFF);
    endtask

    task automatic t_collide();
        logic [31:0] r;
        pulse(2, 12'h0AA);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 4; ev_conv_end = 1; conv_data = 12'h0BB;
        #1 r = bus_rdata;
        check("R7", "read returns older", r, 32'h0AA);
        @(negedge clk); idle();
        do_rd(0, r); check("R7", "read+conv: eoc kept, no ovr", r, 32'h4);
        do_rd(4, r); check("R7", "newer data", r, 32'h0BB);
        pulse(2, 12'h0CC);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 32'h4;
        ev_conv_end = 1; conv_data = 12'h0DD;
        @(negedge clk); idle();
        do_rd(0, r); check("R7", "w1c+conv: eoc kept, no ovr", r, 32'h4);
        do_wr(0, 32'hFFFF_FFFF);
    endtask

    task automatic t_window();
        logic [31:0] r;
        do_wr(2, 32'h100);
        do_wr(3, 32'h200);
        pulse(2, 12'h100); do_rd(0, r); check("R8", "equal low", r & 32'h80, 0);
        pulse(2, 12'h200); do_rd(0, r); check("R8", "equal high", r & 32'h80, 0);
        pulse(2, 12'h0FF); do_rd(0, r); check("R8", "below low", r & 32'h80, 32'h80);
        do_wr(0, 32'hFFFF_FFFF);
        pulse(2, 12'h201); do_rd(0, r); check("R8", "above high", r & 32'h80, 32'h80);
        do_wr(0, 32'hFFFF_FFFF);
        do_wr(2, 32'h0); do_wr(3, 32'hFFF);
    endtask

    task automatic t_irq();
        do_wr(1, 32'h8);
        pulse(0, 0);
        @(negedge clk); check("R9", "masked flag no irq", {31'd0, irq}, 0);
        pulse(3, 0);
        check("R9", "irq one cycle late", {31'd0, irq}, 0);
        @(negedge clk); check("R9", "irq raised", {31'd0, irq}, 1);
        do_wr(0, 32'h8);
        check("R9", "irq still high one cycle", {31'd0, irq}, 1);
        @(negedge clk); check("R9", "irq dropped", {31'd0, irq}, 0);
        do_wr(0, 32'hFFFF_FFFF);
        do_wr(1, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] r;
        do_wr(1, 32'hFFFF_FFFF); do_rd(1, r); check("R10", "enable mask", r, 32'h189F);
        do_wr(2, 32'hFFFF_F123); do_rd(2, r); check("R10", "low width", r, 32'h123);
        do_wr(3, 32'h0000_A456); do_rd(3, r); check("R10", "high width", r, 32'h456);
        do_wr(1, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_flags();
        t_set_wins();
        t_data_read();
        t_overrun();
        t_collide();
        t_window();
        t_irq();
        t_readback();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule